// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns an IEEE-754 binary32 or binary64 operand into a 32-bit or 64-bit integer, signed or unsigned. Five select bits choose the source format, the destination width, the signedness, whether rounding is forced toward zero, and the active rounding mode (nearest-even or toward zero). The block also reports an invalid flag and an inexact flag.

Out-of-range and special operands give fixed results. NaN gives all ones in the destination width. Overflow saturates. Any operand with its sign bit set that is bound for an unsigned destination is refused before any rounding takes place. The datapath is combinational. By default it ends in one output register, so a result appears one clock edge after its operand.

Top module: `f2i_convert`

## Requirements
- R1: A finite in-range operand converted with toward-zero rounding (`rnd_zero`=1) gives its integer part, truncated toward zero, and in-range negatives are returned in two's complement.
- R2: With `rnd_zero`=0 and `chop`=0 the value rounds to the nearest integer, and exact halves go to the even neighbour (0.5 gives 0, 2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R3: `chop`=1 forces truncation toward zero whatever `rnd_zero` holds.
- R4: `inexact` is 1 exactly when a finite, in-range result differs from the operand. Subnormal operands convert normally and give 0 with `inexact`=1.
- R5: For an unsigned destination (`dst_signed`=0), any non-NaN operand whose sign bit is set, including -0.0, -0.3 and -infinity, gives 0 with `invalid`=1.
- R6: A NaN to a signed destination gives -1, which is all ones in the destination width, with `invalid`=1.
- R7: A NaN to an unsigned destination gives the unsigned maximum with `invalid`=1.
- R8: A positive operand, including +infinity, whose rounded value exceeds the destination maximum gives that maximum with `invalid`=1.
- R9: A negative operand to a signed destination whose rounded magnitude exceeds the minimum's magnitude, including -infinity, gives the minimum with `invalid`=1.
- R10: `src_dbl`=0 selects binary32 from `operand[31:0]`, and `operand[63:32]` is then ignored. `dst_wide`=0 gives a 32-bit result in `result[31:0]` with `result[63:32]` zero.
- R11: `invalid` and `inexact` are never 1 together. A result that raises `invalid` reports `inexact`=0.
- R12: With `OUT_REG`=1 each result and its flags appear one rising edge after their inputs. A low `rst_n` at an edge clears `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| src_dbl | input | 1 | 1: operand is binary64; 0: binary32 in bits 31:0 |
| dst_wide | input | 1 | 1: 64-bit destination; 0: 32-bit |
| dst_signed | input | 1 | 1: signed destination; 0: unsigned |
| chop | input | 1 | 1: force rounding toward zero |
| rnd_zero | input | 1 | Active rounding mode: 0 nearest-even, 1 toward zero |
| operand | input | 64 | Floating-point operand |
| result | output | 64 | Converted integer |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Inexact flag |

## Verification
With the default output register, the result and both flags for a set of inputs are due at the first rising edge after those inputs change, and not before. The bench changes inputs on falling edges and reads outputs 1 ns after the next rising edge, so every comparison lands exactly one register stage after its stimulus. A directed test reads the output in the half cycle before that edge and expects the previous vector's result there. A second directed test expects all-zero outputs on the very edge that samples reset low.

// File: rtl/f2i_pkg.sv
// Package: shared widths, limits and the unpacked-operand type used by the
// float-to-integer converter. Assumes IEEE-754 binary32 and binary64 layouts.
package f2i_pkg;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
    localparam int DP_BIAS    = (1 << (DP_EXP_W - 1)) - 1;
    localparam int SIG_W      = DP_FRAC_W + 1;
    localparam int EXP_W      = DP_EXP_W + 2;
    localparam int INT_W      = 64;
    localparam int NARROW_W   = 32;
    localparam int OP_W       = 64;
    localparam int EXT_W      = 2 * INT_W;
    localparam int PT_POS     = INT_W + SIG_W - 1;
    localparam int SH_W       = $clog2(EXT_W);
    localparam int SP_PAD     = DP_FRAC_W - SP_FRAC_W;

    localparam logic [INT_W-1:0] U_WIDE_MAX   = '1;
    localparam logic [INT_W-1:0] U_NARROW_MAX = INT_W'((65'd1 << NARROW_W) - 65'd1);
    localparam logic [INT_W-1:0] S_WIDE_MIN   = INT_W'(65'd1 << (INT_W - 1));
    localparam logic [INT_W-1:0] S_NARROW_MIN = INT_W'(65'd1 << (NARROW_W - 1));
    localparam logic [INT_W-1:0] S_WIDE_MAX   = S_WIDE_MIN - 64'd1;
    localparam logic [INT_W-1:0] S_NARROW_MAX = S_NARROW_MIN - 64'd1;

    typedef struct packed {
        logic                    sign;
        logic                    is_nan;
        logic                    is_inf;
        logic signed [EXP_W-1:0] exp;   // unbiased exponent of sig bit SIG_W-1
        logic [SIG_W-1:0]        sig;   // significand, leading bit at SIG_W-1
    } f2i_num_t;
endpackage

// File: rtl/f2i_unpack.sv
// Module: splits a binary32 or binary64 operand into sign, class, unbiased
// exponent and a left-aligned 53-bit significand. Binary32 fields are taken
// from the low half; subnormals get the minimum exponent and no hidden bit.
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [OP_W-1:0] operand,
    input  logic            src_dbl,
    output f2i_num_t        num
);
    logic [SP_EXP_W-1:0]  sp_e;
    logic [SP_FRAC_W-1:0] sp_f;
    logic [DP_EXP_W-1:0]  dp_e;
    logic [DP_FRAC_W-1:0] dp_f;
    logic                 e_ones, e_zero, f_nz;

    // Field extraction and classification for the selected format.
    always_comb begin
        sp_e = operand[SP_EXP_W+SP_FRAC_W-1:SP_FRAC_W];
        sp_f = operand[SP_FRAC_W-1:0];
        dp_e = operand[DP_EXP_W+DP_FRAC_W-1:DP_FRAC_W];
        dp_f = operand[DP_FRAC_W-1:0];
        if (src_dbl) begin
            e_ones   = &dp_e;
            e_zero   = ~|dp_e;
            f_nz     = |dp_f;
            num.sign = operand[OP_W-1];
            num.sig  = {~e_zero, dp_f};
            num.exp  = e_zero ? EXP_W'(1 - DP_BIAS)
                              : EXP_W'(int'(dp_e) - DP_BIAS);
        end else begin
            e_ones   = &sp_e;
            e_zero   = ~|sp_e;
            f_nz     = |sp_f;
            num.sign = operand[SP_EXP_W+SP_FRAC_W];
            num.sig  = {~e_zero, sp_f, {SP_PAD{1'b0}}};
            num.exp  = e_zero ? EXP_W'(1 - SP_BIAS)
                              : EXP_W'(int'(sp_e) - SP_BIAS);
        end
        num.is_nan = e_ones & f_nz;
        num.is_inf = e_ones & ~f_nz;
    end
endmodule

// File: rtl/f2i_align_round.sv
// Module: shifts the significand to an integer magnitude and rounds it, either
// toward zero or to nearest-even. Reports magnitude overflow (exponent above
// the 64-bit range) and whether any fraction bits were discarded.
module f2i_align_round
    import f2i_pkg::*;
(
    input  logic signed [EXP_W-1:0] exp,
    input  logic [SIG_W-1:0]        sig,
    input  logic                    to_zero,
    output logic [INT_W-1:0]        mag,
    output logic                    too_big,
    output logic                    lost_bits
);
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] below;
    logic [SH_W-1:0]  sh;
    logic [INT_W-1:0] int_part;
    logic             guard, sticky, bump;

    // Alignment, guard/sticky extraction and rounding increment.
    always_comb begin
        ext = {{(EXT_W-INT_W-SIG_W){1'b0}}, sig, {INT_W{1'b0}}};
        if (exp < -EXP_W'(10))
            sh = SH_W'(EXT_W - 1);
        else if (exp > EXP_W'(INT_W - 1))
            sh = SH_W'(PT_POS - INT_W + 1);
        else
            sh = SH_W'(PT_POS - int'(exp));
        int_part  = INT_W'(ext >> sh);
        below     = ext << (EXT_W - int'(sh));
        guard     = below[EXT_W-1];
        sticky    = |below[EXT_W-2:0];
        bump      = ~to_zero & guard & (sticky | int_part[0]);
        mag       = int_part + {{(INT_W-1){1'b0}}, bump};
        lost_bits = guard | sticky;
        too_big   = exp > EXP_W'(INT_W - 1);
    end
endmodule

// File: rtl/f2i_saturate.sv
// Module: applies the special-case and range rules. NaN gives all ones; a set
// sign bit to an unsigned destination is refused before rounding is looked
// at; out-of-range values saturate. Narrow results keep the upper half zero.
module f2i_saturate
    import f2i_pkg::*;
(
    input  f2i_num_t         num,
    input  logic [INT_W-1:0] mag,
    input  logic             too_big,
    input  logic             lost_bits,
    input  logic             dst_wide,
    input  logic             dst_signed,
    output logic [INT_W-1:0] res,
    output logic             inv,
    output logic             inx
);
    logic [INT_W-1:0] pos_lim, neg_lim, width_mask;

    // Destination limits for the selected width and signedness.
    always_comb begin
        width_mask = dst_wide ? U_WIDE_MAX : U_NARROW_MAX;
        neg_lim    = dst_wide ? S_WIDE_MIN : S_NARROW_MIN;
        if (dst_signed) pos_lim = dst_wide ? S_WIDE_MAX : S_NARROW_MAX;
        else            pos_lim = width_mask;
    end

    // Priority selection of the final value and flags.
    always_comb begin
        res = '0;
        inv = 1'b0;
        inx = 1'b0;
        if (num.is_nan) begin
            res = width_mask;
            inv = 1'b1;
        end else if (!dst_signed && num.sign) begin
            inv = 1'b1;
        end else if (num.sign) begin
            if (num.is_inf || too_big || mag > neg_lim) begin
                res = neg_lim;
                inv = 1'b1;
            end else begin
                res = (~mag + 64'd1) & width_mask;
                inx = lost_bits;
            end
        end else if (num.is_inf || too_big || mag > pos_lim) begin
            res = pos_lim;
            inv = 1'b1;
        end else begin
            res = mag;
            inx = lost_bits;
        end
    end
endmodule

// File: rtl/f2i_convert.sv
// Module: top of the float-to-integer converter. Chains unpack, align/round
// and saturate; OUT_REG selects a registered (1) or purely combinational (0)
// output. Reset is synchronous and active low and only affects the register.
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int OUT_REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_dbl,
    input  logic             dst_wide,
    input  logic             dst_signed,
    input  logic             chop,
    input  logic             rnd_zero,
    input  logic [OP_W-1:0]  operand,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    f2i_num_t         num;
    logic [INT_W-1:0] mag;
    logic             too_big, lost_bits;
    logic [INT_W-1:0] res_c;
    logic             inv_c, inx_c;

    f2i_unpack u_unpack (
        .operand (operand),
        .src_dbl (src_dbl),
        .num     (num)
    );

    f2i_align_round u_round (
        .exp       (num.exp),
        .sig       (num.sig),
        .to_zero   (chop | rnd_zero),
        .mag       (mag),
        .too_big   (too_big),
        .lost_bits (lost_bits)
    );

    f2i_saturate u_sat (
        .num        (num),
        .mag        (mag),
        .too_big    (too_big),
        .lost_bits  (lost_bits),
        .dst_wide   (dst_wide),
        .dst_signed (dst_signed),
        .res        (res_c),
        .inv        (inv_c),
        .inx        (inx_c)
    );

    generate
        if (OUT_REG != 0) begin : g_reg
            // Output register holding result and flags.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result  <= '0;
                    invalid <= 1'b0;
                    inexact <= 1'b0;
                end else begin
                    result  <= res_c;
                    invalid <= inv_c;
                    inexact <= inx_c;
                end
            end
        end else begin : g_comb
            assign result  = res_c;
            assign invalid = inv_c;
            assign inexact = inx_c;
        end
    endgenerate
endmodule

// File: rtl/f2i_convert_chk.sv
// Module: property checker bound to f2i_convert. Keeps copies of the inputs
// aligned to the output latency and checks the special-case rules at ports.
module f2i_convert_chk #(
    parameter int OUT_REG = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        src_dbl,
    input logic        dst_wide,
    input logic        dst_signed,
    input logic        chop,
    input logic        rnd_zero,
    input logic [63:0] operand,
    input logic [63:0] result,
    input logic        invalid,
    input logic        inexact
);
    logic [63:0] a_op;
    logic        a_dbl, a_wide, a_sgn;
    logic        a_nan, a_neg;

    generate
        if (OUT_REG != 0) begin : g_dly
            // Input copies delayed to line up with the output register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_op   <= '0;
                    a_dbl  <= 1'b0;
                    a_wide <= 1'b0;
                    a_sgn  <= 1'b0;
                end else begin
                    a_op   <= operand;
                    a_dbl  <= src_dbl;
                    a_wide <= dst_wide;
                    a_sgn  <= dst_signed;
                end
            end
        end else begin : g_now
            assign a_op   = operand;
            assign a_dbl  = src_dbl;
            assign a_wide = dst_wide;
            assign a_sgn  = dst_signed;
        end
    endgenerate

    // Independent classification of the aligned operand.
    always_comb begin
        a_nan = a_dbl ? (&a_op[62:52] && |a_op[51:0]) : (&a_op[30:23] && |a_op[22:0]);
        a_neg = a_dbl ? a_op[63] : a_op[31];
    end

    p_neg_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_sgn && a_neg && !a_nan) |-> (result == 64'd0 && invalid && !inexact));

    p_nan_signed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_nan && a_sgn) |-> (invalid && result == (a_wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF)));

    p_nan_unsigned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_nan && !a_sgn) |-> (invalid && result == (a_wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF)));

    p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !a_wide |-> (result[63:32] == 32'd0));

    p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid && inexact));

    logic unused_ok;
    assign unused_ok = chop ^ rnd_zero;
endmodule

bind f2i_convert f2i_convert_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_dbl    (src_dbl),
    .dst_wide   (dst_wide),
    .dst_signed (dst_signed),
    .chop       (chop),
    .rnd_zero   (rnd_zero),
    .operand    (operand),
    .result     (result),
    .invalid    (invalid),
    .inexact    (inexact)
);

// File: tb/f2i_convert_tb.sv
module f2i_convert_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        src_dbl, dst_wide, dst_signed, chop, rnd_zero;
    logic [63:0] operand;
    logic [63:0] result;
    logic        invalid, inexact;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    f2i_convert #(.OUT_REG(1)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_dbl    (src_dbl),
        .dst_wide   (dst_wide),
        .dst_signed (dst_signed),
        .chop       (chop),
        .rnd_zero   (rnd_zero),
        .operand    (operand),
        .result     (result),
        .invalid    (invalid),
        .inexact    (inexact)
    );

    // Entry: {req[3:0], sel{dbl,wide,signed,chop,rz}[4:0], operand, result, inv, inx}
    localparam int NV = 44;
    localparam logic [138:0] VEC [NV] = '{
        {4'd2,  5'b00100, 64'h0000000040200000, 64'h0000000000000002, 1'b0, 1'b1}, // R2 2.5 -> 2
        {4'd2,  5'b00100, 64'h0000000040600000, 64'h0000000000000004, 1'b0, 1'b1}, // R2 3.5 -> 4
        {4'd2,  5'b00100, 64'h000000003F000000, 64'h0000000000000000, 1'b0, 1'b1}, // R2 0.5 -> 0
        {4'd2,  5'b00100, 64'h000000003FC00000, 64'h0000000000000002, 1'b0, 1'b1}, // R2 1.5 -> 2
        {4'd2,  5'b00100, 64'h00000000C0200000, 64'h00000000FFFFFFFE, 1'b0, 1'b1}, // R2 -2.5 -> -2
        {4'd1,  5'b00101, 64'h0000000040200000, 64'h0000000000000002, 1'b0, 1'b1}, // R1 rz 2.5
        {4'd1,  5'b00101, 64'h0000000040300000, 64'h0000000000000002, 1'b0, 1'b1}, // R1 rz 2.75
        {4'd4,  5'b00100, 64'h0000000040300000, 64'h0000000000000003, 1'b0, 1'b1}, // R4 2.75 RNE -> 3
        {4'd3,  5'b00110, 64'h0000000040300000, 64'h0000000000000002, 1'b0, 1'b1}, // R3 chop 2.75
        {4'd3,  5'b00110, 64'h00000000C0300000, 64'h00000000FFFFFFFE, 1'b0, 1'b1}, // R3 chop -2.75
        {4'd4,  5'b00000, 64'h000000003F800000, 64'h0000000000000001, 1'b0, 1'b0}, // R4 exact 1.0
        {4'd5,  5'b00000, 64'h00000000BE99999A, 64'h0000000000000000, 1'b1, 1'b0}, // R5 -0.3 unsigned
        {4'd5,  5'b00000, 64'h0000000080000000, 64'h0000000000000000, 1'b1, 1'b0}, // R5 -0.0 unsigned
        {4'd1,  5'b00100, 64'h0000000080000000, 64'h0000000000000000, 1'b0, 1'b0}, // R1 -0.0 signed
        {4'd6,  5'b00100, 64'h000000007FC00000, 64'h00000000FFFFFFFF, 1'b1, 1'b0}, // R6 NaN s32
        {4'd6,  5'b01100, 64'h000000007FC00000, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0}, // R6 NaN s64
        {4'd7,  5'b00000, 64'h000000007FC00000, 64'h00000000FFFFFFFF, 1'b1, 1'b0}, // R7 NaN u32
        {4'd8,  5'b00100, 64'h000000004F000000, 64'h000000007FFFFFFF, 1'b1, 1'b0}, // R8 2^31 s32
        {4'd1,  5'b00100, 64'h00000000CF000000, 64'h0000000080000000, 1'b0, 1'b0}, // R1 -2^31 s32
        {4'd1,  5'b00000, 64'h000000004F32D05E, 64'h00000000B2D05E00, 1'b0, 1'b0}, // R1 3e9 u32
        {4'd8,  5'b00000, 64'h000000004F800000, 64'h00000000FFFFFFFF, 1'b1, 1'b0}, // R8 2^32 u32
        {4'd8,  5'b01100, 64'h000000007F800000, 64'h7FFFFFFFFFFFFFFF, 1'b1, 1'b0}, // R8 +inf s64
        {4'd9,  5'b00100, 64'h00000000FF800000, 64'h0000000080000000, 1'b1, 1'b0}, // R9 -inf s32
        {4'd9,  5'b00100, 64'h00000000CF32D05E, 64'h0000000080000000, 1'b1, 1'b0}, // R9 -3e9 s32
        {4'd5,  5'b01000, 64'h00000000FF800000, 64'h0000000000000000, 1'b1, 1'b0}, // R5 -inf u64
        {4'd4,  5'b00100, 64'h0000000000000001, 64'h0000000000000000, 1'b0, 1'b1}, // R4 subnormal
        {4'd2,  5'b11100, 64'h4004000000000000, 64'h0000000000000002, 1'b0, 1'b1}, // R2 dp 2.5
        {4'd2,  5'b11100, 64'hBFF8000000000000, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1}, // R2 dp -1.5
        {4'd3,  5'b11110, 64'hBFF8000000000000, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1}, // R3 dp chop -1.5
        {4'd8,  5'b10100, 64'h4202A05F20000000, 64'h000000007FFFFFFF, 1'b1, 1'b0}, // R8 1e10 s32
        {4'd1,  5'b11000, 64'h4202A05F20000000, 64'h00000002540BE400, 1'b0, 1'b0}, // R1 1e10 u64
        {4'd8,  5'b11100, 64'h43E0000000000000, 64'h7FFFFFFFFFFFFFFF, 1'b1, 1'b0}, // R8 2^63 s64
        {4'd1,  5'b11000, 64'h43E0000000000000, 64'h8000000000000000, 1'b0, 1'b0}, // R1 2^63 u64
        {4'd8,  5'b11000, 64'h43F0000000000000, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0}, // R8 2^64 u64
        {4'd1,  5'b11100, 64'hC3E0000000000000, 64'h8000000000000000, 1'b0, 1'b0}, // R1 -2^63 s64
        {4'd5,  5'b11000, 64'hBFD3333333333333, 64'h0000000000000000, 1'b1, 1'b0}, // R5 dp -0.3 u64
        {4'd2,  5'b11100, 64'hBFD3333333333333, 64'h0000000000000000, 1'b0, 1'b1}, // R2 dp -0.3 s64
        {4'd7,  5'b11000, 64'h7FF8000000000000, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0}, // R7 dp NaN u64
        {4'd6,  5'b10100, 64'h7FF8000000000000, 64'h00000000FFFFFFFF, 1'b1, 1'b0}, // R6 dp NaN s32
        {4'd4,  5'b11000, 64'h0000000000000001, 64'h0000000000000000, 1'b0, 1'b1}, // R4 dp subnormal
        {4'd10, 5'b00100, 64'hDEADBEEF3F800000, 64'h0000000000000001, 1'b0, 1'b0}, // R10 upper ignored
        {4'd1,  5'b10001, 64'h4004000000000000, 64'h0000000000000002, 1'b0, 1'b1}, // R1 dp rz u32
        {4'd11, 5'b10000, 64'h41EFFFFFFFF00000, 64'h00000000FFFFFFFF, 1'b1, 1'b0}, // R11 round-up overflow
        {4'd3,  5'b10010, 64'h41EFFFFFFFF00000, 64'h00000000FFFFFFFF, 1'b0, 1'b1}  // R3 chop keeps in range
    };

    task automatic check(input int req, input logic [63:0] er, input logic ei,
                         input logic ex, input string what);
        n_run++;
        if (result !== er || invalid !== ei || inexact !== ex) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h inv=%b inx=%b, expected %h inv=%b inx=%b",
                     req, what, result, invalid, inexact, er, ei, ex);
        end
    endtask

    task automatic drive(input logic [4:0] sel, input logic [63:0] op);
        @(negedge clk);
        {src_dbl, dst_wide, dst_signed, chop, rnd_zero} = sel;
        operand = op;
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL R12 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        {src_dbl, dst_wide, dst_signed, chop, rnd_zero} = 5'b0;
        operand = 64'h0000000040600000;
        repeat (3) @(posedge clk);
        #1 check(12, 64'd0, 1'b0, 1'b0, "reset clears outputs");   // R12
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][134:130], VEC[i][129:66]);
            @(posedge clk);
            #1 check(int'(VEC[i][138:135]), VEC[i][65:2], VEC[i][1], VEC[i][0], $sformatf("vector %0d", i));
        end

        // R12 latency: the output holds the previous result until the next edge
        drive(5'b00100, 64'h000000003F800000);
        @(posedge clk);
        #1 check(12, 64'd1, 1'b0, 1'b0, "latency first");
        drive(5'b00100, 64'h0000000040600000);
        #1 check(12, 64'd1, 1'b0, 1'b0, "held before edge");
        @(posedge clk);
        #1 check(12, 64'd4, 1'b0, 1'b1, "due after one edge");

        // R12 reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 check(12, 64'd0, 1'b0, 1'b0, "reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check(2, 64'd4, 1'b0, 1'b1, "resume after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule